// File: doc/BRIEF.md
# Direct-Mapped Line Cache with Write-Through

This block is a direct-mapped cache that sits between a 32-bit processor port and a slower, word-wide memory. With the default parameters it holds 16 KB as 1024 lines, each line carrying four 32-bit words, one tag and one valid bit. A processor access selects one line by its index field and compares one tag. If the line is valid and the tag matches, the access is a hit. If the line is not valid, the access is a plain miss. If the line is valid but holds another tag, the access is a miss that evicts the old line.

Read hits complete in the cycle they are presented. A miss stalls the processor while four words are fetched over a request/acknowledge memory port. When the refill is done, the read completes from the new line. Writes are write-through. A write hit updates the line and then writes the word to memory. A write miss first refills the whole line, merges the written word into it, and then writes the word to memory. Each completed access reports its outcome class on a status output.

The controller is a four-state machine:
- `ST_IDLE` looks up the address.
- `ST_FILL` fetches the line.
- `ST_WRITE` sends the write-through word.
- `ST_DONE` completes a stalled access.

The transitions are:
- IDLE→IDLE on a read hit or when there is no request.
- IDLE→FILL on any miss.
- IDLE→WRITE on a write hit.
- FILL→FILL on each acknowledged word except the last.
- FILL→DONE on the last word of a read.
- FILL→WRITE on the last word of a write.
- WRITE→DONE on the write acknowledge.
- DONE→IDLE always.

Top module: `dm_cache`

## Requirements
- R1: A byte address splits into a word select at bits [3:2], an index at bits [IDX_W+3:4] and a tag above it. Two addresses that share an index but differ in tag compete for the same single line.
- R2: After reset every line is invalid. The first access to any index is a plain miss, reported as outcome 2.
- R3: A read hit asserts `cpu_ready` in the same cycle as the request and reports outcome 1 (hit). It returns the word chosen by bits [3:2] and issues no memory traffic.
- R4: A read miss on an invalid line stalls the processor, refills the line, and then completes with outcome 2 and the requested word.
- R5: An access to a valid line with a different tag reports outcome 3 (miss with replacement). The old contents are discarded, so a later access to the evicted address also misses.
- R6: A refill issues exactly four memory reads at the line base, in ascending word order (word 0 first). The tag and valid bit are installed when the fourth word arrives.
- R7: A write hit reports outcome 1. It updates the cached word and also writes that word to memory, with no refill.
- R8: A write miss refills all four words, merges the written word, and writes the word to memory. Later reads of the line hit and return the new word and the unchanged memory words.
- R9: Read data always equals the current memory contents, whether the access hits or misses.
- R10: `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_ack`. Each acknowledge moves exactly one word, and a write access makes exactly one memory write.
- R11: `cpu_ready` is low from the cycle a miss or write is seen until the access completes, and it is low whenever memory is requested. `cpu_outcome` is nonzero only while `cpu_req` and `cpu_ready` are both high. Outcome 0 means no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all valid bits |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_rdata | output | DATA_W | Read word, valid when `cpu_req` and `cpu_ready` are high |
| cpu_ready | output | 1 | Access complete (low means stall) |
| cpu_outcome | output | 2 | 0 none, 1 hit, 2 miss, 3 miss with replacement |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Word-aligned memory byte address |
| mem_wdata | output | DATA_W | Memory write word |
| mem_rdata | input | DATA_W | Memory read word, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle acknowledge for one word |

## Verification
The bench builds the cache with `IDX_W` set to 4, which gives 16 lines. Address bits [11:8] therefore act as the tag, and a 4 KB reference memory is enough to force conflicts on demand. A sweep over that space wraps every line several times, so it exercises plain misses, replacements on reads and on writes, and write hits. The memory model answers after two wait cycles, which puts the stable-request, refill-order and stall rules under real back-pressure.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } state_t;

    typedef enum logic [1:0] {
        OC_NONE = 2'd0,
        OC_HIT  = 2'd1,
        OC_MISS = 2'd2,
        OC_REPL = 2'd3
    } outcome_t;

endpackage

// File: rtl/dmc_store.sv
module dmc_store #(
    parameter int IDX_W  = 10,
    parameter int TAG_W  = 18,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [LINE_W-1:0] line_q [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            line_q[wr_idx] <= wr_line;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_line  = line_q[rd_idx];

endmodule

// File: rtl/dmc_fsm.sv
module dmc_fsm
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 10,
    parameter int WORDS  = 4,
    localparam int BYTE_W = $clog2(DATA_W / 8),
    localparam int WSEL_W = $clog2(WORDS),
    localparam int OFF_W  = BYTE_W + WSEL_W,
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
    localparam int LINE_W = DATA_W * WORDS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req,
    input  logic                   we,
    input  logic [ADDR_W-1:BYTE_W] addr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic                   hit,
    input  logic                   line_valid,
    input  logic [LINE_W-1:0]      rd_line,
    output logic [IDX_W-1:0]       look_idx,
    output logic [TAG_W-1:0]       look_tag,
    output logic                   cpu_ready,
    output logic [DATA_W-1:0]      cpu_rdata,
    output outcome_t               cpu_outcome,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [DATA_W-1:0]      mem_wdata,
    input  logic [DATA_W-1:0]      mem_rdata,
    input  logic                   mem_ack,
    output logic                   wr_en,
    output logic [IDX_W-1:0]       wr_idx,
    output logic [TAG_W-1:0]       wr_tag,
    output logic [LINE_W-1:0]      wr_line
);
    state_t                   state_q, state_d;
    logic [ADDR_W-1:BYTE_W]   a_q, cur_a;
    logic                     we_q, cur_we;
    logic [DATA_W-1:0]        wd_q, cur_wd;
    outcome_t                 oc_q;
    logic [WSEL_W-1:0]        cnt_q, sel;
    logic [DATA_W-1:0]        buf_q [WORDS];
    logic                     idle_req, last_beat;

    // The live request is used in IDLE; latched copies are used afterwards.
    assign idle_req  = (state_q == ST_IDLE) && req;
    assign cur_a     = (state_q == ST_IDLE) ? addr  : a_q;
    assign cur_we    = (state_q == ST_IDLE) ? we    : we_q;
    assign cur_wd    = (state_q == ST_IDLE) ? wdata : wd_q;
    assign sel       = cur_a[OFF_W-1:BYTE_W];
    assign look_idx  = cur_a[OFF_W+IDX_W-1:OFF_W];
    assign look_tag  = cur_a[ADDR_W-1:OFF_W+IDX_W];
    assign last_beat = (state_q == ST_FILL) && mem_ack && (cnt_q == WSEL_W'(WORDS - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req && !(hit && !we)) state_d = hit ? ST_WRITE : ST_FILL;
            ST_FILL:  if (last_beat)            state_d = we_q ? ST_WRITE : ST_DONE;
            ST_WRITE: if (mem_ack)              state_d = ST_DONE;
            ST_DONE:                            state_d = ST_IDLE;
        endcase
    end

    // Request latch, beat counter and refill buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (idle_req) begin
            cnt_q <= '0;
        end else if ((state_q == ST_FILL) && mem_ack) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (idle_req) begin
            a_q  <= addr;
            we_q <= we;
            wd_q <= wdata;
            oc_q <= hit ? OC_HIT : (line_valid ? OC_REPL : OC_MISS);
        end
        if ((state_q == ST_FILL) && mem_ack) buf_q[cnt_q] <= mem_rdata;
    end

    // Line image for the store: refill words or the current line, with the
    // written word merged in
    always_comb begin
        for (int w = 0; w < WORDS; w++) begin
            if (state_q == ST_FILL)
                wr_line[w*DATA_W +: DATA_W] = (w == WORDS - 1) ? mem_rdata : buf_q[w];
            else
                wr_line[w*DATA_W +: DATA_W] = rd_line[w*DATA_W +: DATA_W];
            if (cur_we && (sel == WSEL_W'(w)))
                wr_line[w*DATA_W +: DATA_W] = cur_wd;
        end
    end

    assign wr_en  = (idle_req && we && hit) || last_beat;
    assign wr_idx = look_idx;
    assign wr_tag = look_tag;

    // Outputs
    always_comb begin
        cpu_ready   = 1'b0;
        cpu_outcome = OC_NONE;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = {a_q, BYTE_W'(0)};
        mem_wdata   = wd_q;
        cpu_rdata   = rd_line[sel*DATA_W +: DATA_W];
        unique case (state_q)
            ST_IDLE: begin
                cpu_ready = !req || (hit && !we);
                if (req && hit && !we) cpu_outcome = OC_HIT;
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {a_q[ADDR_W-1:OFF_W], cnt_q, BYTE_W'(0)};
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_DONE: begin
                cpu_ready   = 1'b1;
                cpu_outcome = oc_q;
            end
        endcase
    end

endmodule

// File: rtl/dm_cache.sv
module dm_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 10,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic [1:0]        cpu_outcome,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int OFF_W  = BYTE_W + $clog2(WORDS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = DATA_W * WORDS;

    logic [IDX_W-1:0]  look_idx, wr_idx;
    logic [TAG_W-1:0]  look_tag, rd_tag, wr_tag;
    logic [LINE_W-1:0] rd_line, wr_line;
    logic              rd_valid, hit, wr_en;
    outcome_t          oc;

    assign hit         = rd_valid && (rd_tag == look_tag);
    assign cpu_outcome = oc;

    dmc_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(look_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_line(rd_line),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_line(wr_line)
    );

    dmc_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .WORDS(WORDS)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req(cpu_req), .we(cpu_we), .addr(cpu_addr[ADDR_W-1:BYTE_W]), .wdata(cpu_wdata),
        .hit(hit), .line_valid(rd_valid), .rd_line(rd_line),
        .look_idx(look_idx), .look_tag(look_tag),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .cpu_outcome(oc),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_line(wr_line)
    );

endmodule

// File: rtl/dm_cache_chk.sv
module dm_cache_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              cpu_ready,
    input logic [1:0]        cpu_outcome,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack
);
    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int OFF_W  = BYTE_W + $clog2(WORDS);

    // R11: no completion while memory is busy
    a_r11_stall_during_mem: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);

    // R11: outcome only reported on a completing access
    a_r11_outcome_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_outcome != 2'd0) |-> (cpu_ready && cpu_req));

    // R10: request held stable until acknowledged
    a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R6: a refill starts at word 0 of the line
    a_r6_fill_from_base: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) && !mem_we) |-> (mem_addr[OFF_W-1:BYTE_W] == '0));

    // R6: refill words advance in ascending order
    a_r6_fill_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack && (mem_addr[OFF_W-1:BYTE_W] != {(OFF_W-BYTE_W){1'b1}}))
        |=> (mem_req && !mem_we &&
             (mem_addr[OFF_W-1:BYTE_W] == $past(mem_addr[OFF_W-1:BYTE_W]) + 1'b1)));

    // R3: a read hit makes no memory request
    a_r3_hit_no_traffic: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && cpu_ready && (cpu_outcome == 2'd1)) |-> !mem_req);

    // R7: a write completes only right after its memory write was acknowledged
    a_r7_write_reaches_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && cpu_ready) |-> $past(mem_req && mem_we && mem_ack));

endmodule

bind dm_cache dm_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_ready(cpu_ready), .cpu_outcome(cpu_outcome), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/dm_cache_test.sv
`timescale 1ns/1ps
module dm_cache_test;
    localparam int AW  = 32;
    localparam int DW  = 32;
    localparam int IW  = 4;
    localparam int LAT = 2;
    localparam int MW  = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_ready;
    logic [1:0]    cpu_outcome;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_ack = 1'b0;

    int errors = 0;
    int checks = 0;

    logic [DW-1:0] mem     [MW];
    logic [DW-1:0] ref_mem [MW];
    logic [AW-1:0] rd_log  [16];
    int            rd_n = 0;
    int            wr_n = 0;
    int            wait_cnt = 0;

    always #2.5 clk = ~clk;

    dm_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .WORDS(4)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .cpu_outcome(cpu_outcome), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // Memory model: acknowledges each word after LAT wait cycles
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack  <= 1'b0;
            wait_cnt <= 0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (wait_cnt == LAT) begin
                    mem_ack  <= 1'b1;
                    wait_cnt <= 0;
                    if (mem_we) begin
                        mem[mem_addr[11:2]] <= mem_wdata;
                        wr_n <= wr_n + 1;
                    end else begin
                        mem_rdata <= mem[mem_addr[11:2]];
                        if (rd_n < 16) rd_log[rd_n] <= mem_addr;
                        rd_n <= rd_n + 1;
                    end
                end else begin
                    wait_cnt <= wait_cnt + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output logic [DW-1:0] rd, output logic [1:0] oc, output int waits);
        @(negedge clk);
        rd_n = 0;
        wr_n = 0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        waits = 0;
        #1;
        while (!cpu_ready && waits < 500) begin
            @(negedge clk); #1;
            waits++;
        end
        rd = cpu_rdata;
        oc = cpu_outcome;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        if (we) ref_mem[a[11:2]] = d;
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk(cpu_ready == 1'b1, "R11 idle ready", {31'b0, cpu_ready}, 32'd1);
        chk(cpu_outcome == 2'd0, "R11 idle outcome", {30'b0, cpu_outcome}, 32'd0);
        chk(mem_req == 1'b0, "R2 no memory after reset", {31'b0, mem_req}, 32'd0);
    endtask

    task automatic t_read_miss();
        logic [DW-1:0] rd; logic [1:0] oc; int w;
        access(1'b0, 32'h014, '0, rd, oc, w);
        chk(oc == 2'd2, "R2 first access plain miss", {30'b0, oc}, 32'd2);
        chk(rd == ref_mem[5], "R4 read miss data", rd, ref_mem[5]);
        chk(w > 0, "R11 miss stalls", w, 32'd1);
        chk(rd_n == 4, "R6 four refill reads", rd_n, 32'd4);
        for (int k = 0; k < 4; k++)
            chk(rd_log[k] == 32'h010 + 4 * k, "R6 refill order", rd_log[k], 32'h010 + 4 * k);
    endtask

    task automatic t_read_hit();
        logic [DW-1:0] rd; logic [1:0] oc; int w;
        access(1'b0, 32'h01C, '0, rd, oc, w);
        chk(oc == 2'd1, "R3 hit outcome", {30'b0, oc}, 32'd1);
        chk(w == 0, "R3 hit no stall", w, 32'd0);
        chk(rd_n == 0, "R3 hit no memory read", rd_n, 32'd0);
        chk(rd == ref_mem[7], "R1 word select 3", rd, ref_mem[7]);
        access(1'b0, 32'h010, '0, rd, oc, w);
        chk(rd == ref_mem[4], "R1 word select 0", rd, ref_mem[4]);
    endtask

    task automatic t_replace();
        logic [DW-1:0] rd; logic [1:0] oc; int w;
        access(1'b0, 32'h114, '0, rd, oc, w);
        chk(oc == 2'd3, "R1 same index conflicts / R5 replace", {30'b0, oc}, 32'd3);
        chk(rd == ref_mem[32'h45], "R5 replaced data", rd, ref_mem[32'h45]);
        access(1'b0, 32'h014, '0, rd, oc, w);
        chk(oc == 2'd3, "R5 evicted line misses", {30'b0, oc}, 32'd3);
        chk(rd == ref_mem[5], "R9 data after eviction", rd, ref_mem[5]);
    endtask

    task automatic t_write_hit();
        logic [DW-1:0] rd; logic [1:0] oc; int w;
        access(1'b1, 32'h018, 32'hCAFE_0001, rd, oc, w);
        chk(oc == 2'd1, "R7 write hit outcome", {30'b0, oc}, 32'd1);
        chk(rd_n == 0, "R7 write hit no refill", rd_n, 32'd0);
        chk(wr_n == 1, "R10 one memory write", wr_n, 32'd1);
        chk(mem[6] == 32'hCAFE_0001, "R7 write-through", mem[6], 32'hCAFE_0001);
        access(1'b0, 32'h018, '0, rd, oc, w);
        chk(oc == 2'd1 && rd == 32'hCAFE_0001, "R7 cached word updated", rd, 32'hCAFE_0001);
    endtask

    task automatic t_write_miss();
        logic [DW-1:0] rd; logic [1:0] oc; int w;
        access(1'b1, 32'h2A8, 32'hBEEF_0002, rd, oc, w);
        chk(oc == 2'd2, "R8 write miss outcome", {30'b0, oc}, 32'd2);
        chk(rd_n == 4, "R8 write miss refills line", rd_n, 32'd4);
        chk(mem[32'hAA] == 32'hBEEF_0002, "R8 write miss to memory", mem[32'hAA], 32'hBEEF_0002);
        access(1'b0, 32'h2A8, '0, rd, oc, w);
        chk(oc == 2'd1 && rd == 32'hBEEF_0002, "R8 merged word hits", rd, 32'hBEEF_0002);
        access(1'b0, 32'h2A4, '0, rd, oc, w);
        chk(oc == 2'd1 && rd == ref_mem[32'hA9], "R8 neighbour word", rd, ref_mem[32'hA9]);
        access(1'b1, 32'h3A0, 32'hD00D_0003, rd, oc, w);
        chk(oc == 2'd3, "R5 write miss replaces", {30'b0, oc}, 32'd3);
        access(1'b0, 32'h2A8, '0, rd, oc, w);
        chk(oc == 2'd3 && rd == 32'hBEEF_0002, "R9 evicted written word", rd, 32'hBEEF_0002);
    endtask

    task automatic t_sweep();
        logic [DW-1:0] rd; logic [1:0] oc; int w;
        for (int i = 0; i < 80; i++) begin
            logic [AW-1:0] a;
            a = (i * 32'h34 + (i >> 3) * 32'h104) & 32'hFFC;
            if (i % 5 == 2)
                access(1'b1, a, 32'h1234_0000 + i, rd, oc, w);
            else begin
                access(1'b0, a, '0, rd, oc, w);
                chk(rd == ref_mem[a[11:2]], "R9 sweep read", rd, ref_mem[a[11:2]]);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < MW; i++) begin
            mem[i]     = (i * 32'h9E37_79B1) ^ 32'h5A5A_0000;
            ref_mem[i] = (i * 32'h9E37_79B1) ^ 32'h5A5A_0000;
        end
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_read_miss();
        t_read_hit();
        t_replace();
        t_write_hit();
        t_write_miss();
        t_sweep();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule